// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block counts ticks of a slow low-power clock, delivered as a one-cycle enable on the system clock, and requests action if software fails to service it in time. Ticks first pass a prescaler that divides by 32 or 128. The prescaler output then drives a postscaler whose ratio is a power of two between 2^0 and 2^15. One timeout period is therefore 2^(5 or 7 + sel) ticks.

A timeout in normal operation raises a one-cycle reset request. A timeout while the system is in sleep or idle raises a one-cycle wake-up request instead. Either kind of timeout sets a sticky flag that only a software strobe clears. In window mode, a service clear that arrives before the last quarter of the period is treated as a fault and also raises the reset request. Several system events restart the count: a system reset, a completed clock switch, entry into power save, a return from sleep or idle, and a service clear.

The watchdog runs whenever the hardware enable is set. When the hardware enable is clear, it runs only while an internal software-enable bit is set. A system reset clears that bit.

Top module: `lp_watchdog`

## Requirements
- R1: With tick held high, postscale select 0 and the watchdog running, the first timeout pulse appears 32 clock edges after reset is released when `long_pre`=0, and 128 edges after when `long_pre`=1.
- R2: The period scales as 2^`post_sel`. With `long_pre`=0, sel=1 gives 64 ticks and sel=2 gives 128 ticks. With `long_pre`=1, sel=1 gives 256 ticks.
- R3: The count advances only on clock edges where `tick` is 1. With ticks on alternate edges and a 32-tick period, the timeout appears at edge 63.
- R4: With `hw_en`=1 the watchdog runs. With `hw_en`=0 it runs only while the software-enable bit is 1. That bit is loaded from `swen_d` when `swen_we` is 1, and counting starts on the edge after the write.
- R5: A system reset clears the software-enable bit. With `hw_en`=0, no timeout occurs after a reset until the bit is written again.
- R6: A one-cycle strobe on `cswitch_done`, `pwrsave` or `clr`, or a fall of (`sleep`|`idle`) to 0, restarts the count on the next edge. The next timeout then follows one full period after that edge.
- R7: With `win_dis`=0, a `clr` seen while the combined count is below 3/4 of the period gives `rst_req` high on the next edge and restarts the count. For a 32-tick period, a clear at count 23 is early and a clear at count 24 is accepted.
- R8: A timeout while `sleep` or `idle` is 1 gives a one-cycle `wake_req` and no `rst_req`. Otherwise a timeout gives a one-cycle `rst_req`. The two requests are never high together.
- R9: `to_flag` is 0 at power-up and is set by every timeout. It is not cleared by a later timeout or by `rst`. A `flag_clr` strobe clears it, except that a timeout on the same edge wins.
- R10: While the watchdog is disabled, the count is held at zero, no request is raised, and `clr` has no effect, including the window check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| tick | input | 1 | One-cycle enable carrying the slow clock tick |
| long_pre | input | 1 | Prescaler select: 0 divides by 32, 1 divides by 128 |
| post_sel | input | 4 | Postscaler exponent, ratio 2^post_sel |
| win_dis | input | 1 | 1 disables window mode |
| hw_en | input | 1 | Hardware enable, forces the watchdog on |
| swen_we | input | 1 | Write strobe for the software-enable bit |
| swen_d | input | 1 | Value written to the software-enable bit |
| clr | input | 1 | Service clear strobe |
| pwrsave | input | 1 | Power-save entry strobe |
| sleep | input | 1 | System is in sleep |
| idle | input | 1 | System is in idle |
| cswitch_done | input | 1 | Clock-switch completion strobe |
| flag_clr | input | 1 | Software strobe that clears the timeout flag |
| rst_req | output | 1 | One-cycle reset request |
| wake_req | output | 1 | One-cycle wake-up request |
| to_flag | output | 1 | Sticky timeout flag |

## Verification
The assertions check, on every cycle, the following properties:
- Both requests stay exclusive.
- A wake request lasts one cycle.
- The flag holds unless it is cleared, and every wake request comes with the flag set.
- An early clear in window mode always produces a reset request.
- A disabled watchdog holds its counters at zero and raises nothing.
- A reset clears the software-enable bit.

Only the bench scenarios can show the exact timeout latency for each prescale and postscale setting and the effect of sparse ticks. They also show the window boundary at counts 23 and 24, the restart caused by each system event, and the flag surviving a reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int PRE_SHORT_LOG2 = 5;
  localparam int PRE_LONG_LOG2  = 7;
  localparam int SEL_W          = 4;

  typedef enum logic [1:0] {
    OUT_NONE  = 2'd0,
    OUT_RESET = 2'd1,
    OUT_WAKE  = 2'd2
  } wdt_out_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int SHORT_LOG2 = 5,
  parameter int LONG_LOG2  = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 restart,
  input  logic                 tick,
  input  logic                 long_pre,
  output logic [LONG_LOG2-1:0] cnt,
  output logic                 carry
);
  localparam logic [LONG_LOG2-1:0] LIM_SHORT = LONG_LOG2'((1 << SHORT_LOG2) - 1);
  localparam logic [LONG_LOG2-1:0] LIM_LONG  = LONG_LOG2'((1 << LONG_LOG2) - 1);

  logic [LONG_LOG2-1:0] lim;
  assign lim   = long_pre ? LIM_LONG : LIM_SHORT;
  assign carry = tick && !restart && (cnt >= lim);

  always_ff @(posedge clk) begin
    if (rst || restart)
      cnt <= '0;
    else if (tick)
      cnt <= carry ? '0 : cnt + 1'b1;
  end

  AST_PRE_HOLD: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0)); // R10
endmodule

// File: rtl/wdt_postscaler.sv
module wdt_postscaler #(
  parameter int SEL_W = 4,
  parameter int CNT_W = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             inc,
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] cnt,
  output logic             term
);
  logic [CNT_W:0]   lim_wide;
  logic [CNT_W-1:0] lim;

  assign lim_wide = ((CNT_W+1)'(1) << sel) - 1'b1;
  assign lim      = lim_wide[CNT_W-1:0];
  assign term     = inc && (cnt >= lim);

  always_ff @(posedge clk) begin
    if (rst || restart)
      cnt <= '0;
    else if (inc)
      cnt <= term ? '0 : cnt + 1'b1;
  end

  AST_POST_HOLD: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0)); // R6
endmodule

// File: rtl/wdt_window.sv
module wdt_window #(
  parameter int SHORT_LOG2 = 5,
  parameter int LONG_LOG2  = 7,
  parameter int SEL_W      = 4,
  parameter int POST_W     = (1 << SEL_W) - 1,
  parameter int CW         = POST_W + LONG_LOG2
) (
  input  logic                 long_pre,
  input  logic [SEL_W-1:0]     sel,
  input  logic [LONG_LOG2-1:0] pre_cnt,
  input  logic [POST_W-1:0]    post_cnt,
  output logic                 in_window
);
  int          plog;
  logic [CW-1:0] combined;
  logic [CW-1:0] thresh;

  always_comb begin
    plog      = long_pre ? LONG_LOG2 : SHORT_LOG2;
    combined  = (CW'(post_cnt) << plog) + CW'(pre_cnt);
    thresh    = CW'(3) << (plog + int'(sel) - 2);
    in_window = (combined >= thresh);
  end
endmodule

// File: rtl/lp_watchdog.sv
module lp_watchdog
  import wdt_pkg::*;
#(
  parameter int SHORT_LOG2 = wdt_pkg::PRE_SHORT_LOG2,
  parameter int LONG_LOG2  = wdt_pkg::PRE_LONG_LOG2,
  parameter int SW         = wdt_pkg::SEL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          long_pre,
  input  logic [SW-1:0] post_sel,
  input  logic          win_dis,
  input  logic          hw_en,
  input  logic          swen_we,
  input  logic          swen_d,
  input  logic          clr,
  input  logic          pwrsave,
  input  logic          sleep,
  input  logic          idle,
  input  logic          cswitch_done,
  input  logic          flag_clr,
  output logic          rst_req,
  output logic          wake_req,
  output logic          to_flag
);
  localparam int POST_W = (1 << SW) - 1;

  logic swen_q, slp_q, flag_q = 1'b0;
  logic en, slp, wake_exit, restart, early_clr, in_win, timeout;
  logic pre_carry, post_term;
  logic [LONG_LOG2-1:0] pre_cnt;
  logic [POST_W-1:0]    post_cnt;
  wdt_out_e out_d, out_q;

  assign en        = hw_en | swen_q;
  assign slp       = sleep | idle;
  assign wake_exit = slp_q & ~slp;
  assign restart   = ~en | cswitch_done | pwrsave | wake_exit | clr;
  assign early_clr = en & clr & ~win_dis & ~in_win;
  assign timeout   = en & post_term;

  wdt_prescaler #(.SHORT_LOG2(SHORT_LOG2), .LONG_LOG2(LONG_LOG2)) u_pre (
    .clk(clk), .rst(rst), .restart(restart), .tick(tick),
    .long_pre(long_pre), .cnt(pre_cnt), .carry(pre_carry));

  wdt_postscaler #(.SEL_W(SW), .CNT_W(POST_W)) u_post (
    .clk(clk), .rst(rst), .restart(restart), .inc(pre_carry),
    .sel(post_sel), .cnt(post_cnt), .term(post_term));

  wdt_window #(.SHORT_LOG2(SHORT_LOG2), .LONG_LOG2(LONG_LOG2), .SEL_W(SW),
               .POST_W(POST_W)) u_win (
    .long_pre(long_pre), .sel(post_sel), .pre_cnt(pre_cnt),
    .post_cnt(post_cnt), .in_window(in_win));

  always_comb begin
    out_d = OUT_NONE;
    if (early_clr)          out_d = OUT_RESET;
    else if (timeout & slp) out_d = OUT_WAKE;
    else if (timeout)       out_d = OUT_RESET;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      swen_q <= 1'b0;
      slp_q  <= 1'b0;
      out_q  <= OUT_NONE;
    end else begin
      if (swen_we) swen_q <= swen_d;
      slp_q <= slp;
      out_q <= out_d;
    end
  end

  // Flag survives system reset; power-up value comes from the declaration.
  always_ff @(posedge clk) begin
    if (timeout)       flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  assign rst_req  = (out_q == OUT_RESET);
  assign wake_req = (out_q == OUT_WAKE);
  assign to_flag  = flag_q;

  AST_SWEN_CLEARED: assert property (@(posedge clk)
    rst |=> !swen_q); // R5
  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rst_req && wake_req)); // R8
  AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (rst)
    wake_req |=> !wake_req); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (to_flag && !flag_clr) |=> to_flag); // R9
  AST_WAKE_FLAG: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> to_flag); // R9
  AST_EARLY_CLR: assert property (@(posedge clk) disable iff (rst)
    (en && clr && !win_dis && !in_win) |=> rst_req); // R7
  AST_DIS_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!rst_req && !wake_req)); // R10
  AST_DIS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !en |=> (post_cnt == '0)); // R10
endmodule

// File: tb/sim_lp_watchdog.sv
`timescale 1ns/1ps
module sim_lp_watchdog;
  logic clk = 1'b0, rst = 1'b1, tick = 1'b1, long_pre = 1'b0;
  logic [3:0] post_sel = '0;
  logic win_dis = 1'b1, hw_en = 1'b1, swen_we = 1'b0, swen_d = 1'b0;
  logic clr = 1'b0, pwrsave = 1'b0, sleep = 1'b0, idle = 1'b0;
  logic cswitch_done = 1'b0, flag_clr = 1'b0;
  logic rst_req, wake_req, to_flag;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  lp_watchdog u0 (
    .clk(clk), .rst(rst), .tick(tick), .long_pre(long_pre),
    .post_sel(post_sel), .win_dis(win_dis), .hw_en(hw_en),
    .swen_we(swen_we), .swen_d(swen_d), .clr(clr), .pwrsave(pwrsave),
    .sleep(sleep), .idle(idle), .cswitch_done(cswitch_done),
    .flag_clr(flag_clr), .rst_req(rst_req), .wake_req(wake_req),
    .to_flag(to_flag));

  // fields: long_pre, post_sel, tick spacing, low-power mode (0 none,1 sleep,2 idle), latency
  localparam int NV = 6;
  localparam int VEC [NV][5] = '{
    '{0, 0, 1, 0, 32},
    '{1, 0, 1, 0, 128},
    '{0, 1, 1, 0, 64},
    '{0, 2, 1, 2, 128},
    '{1, 1, 1, 1, 256},
    '{0, 0, 2, 0, 63}
  };

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drop_strobes();
    clr = 0; pwrsave = 0; cswitch_done = 0; flag_clr = 0; swen_we = 0;
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk); #1;
      drop_strobes();
    end
  endtask

  task automatic do_reset();
    rst = 1; step(2); rst = 0;
  endtask

  task automatic wait_pulse(input int maxc, input int every, output int lat, output int wk);
    lat = -1; wk = 0;
    for (int k = 0; k < maxc; k++) begin
      tick = ((k % every) == 0);
      @(posedge clk); #1;
      drop_strobes();
      if (rst_req || wake_req) begin
        lat = k + 1; wk = int'(wake_req);
        break;
      end
    end
    tick = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int lat, wk;
    check("R9 power-up flag", int'(to_flag), 0);
    do_reset();
    check("R8 reset state rst_req", int'(rst_req), 0);
    check("R8 reset state wake_req", int'(wake_req), 0);

    // Table walk: R1 R2 R3 R8
    for (int v = 0; v < NV; v++) begin
      long_pre = VEC[v][0][0]; post_sel = 4'(VEC[v][1]);
      sleep = (VEC[v][3] == 1); idle = (VEC[v][3] == 2);
      do_reset();
      wait_pulse(600, VEC[v][2], lat, wk);
      check($sformatf("R1/R2/R3 vector %0d latency", v), lat, VEC[v][4]);
      check($sformatf("R8 vector %0d wake kind", v), wk, int'(VEC[v][3] != 0));
      step(1);
      check($sformatf("R8 vector %0d one-cycle", v), int'(rst_req | wake_req), 0);
      check($sformatf("R9 vector %0d flag", v), int'(to_flag), 1);
      sleep = 0; idle = 0;
    end
    long_pre = 0; post_sel = 0;

    // R9 sticky across reset, clear, timeout wins
    do_reset();
    check("R9 flag survives reset", int'(to_flag), 1);
    flag_clr = 1; step(1);
    check("R9 flag_clr clears", int'(to_flag), 0);
    do_reset(); step(31); flag_clr = 1; step(1);
    check("R9 timeout pulse same edge", int'(rst_req), 1);
    check("R9 timeout beats flag_clr", int'(to_flag), 1);
    do_reset(); wait_pulse(100, 1, lat, wk);
    check("R9 second timeout keeps flag", int'(to_flag), 1);
    flag_clr = 1; step(1);

    // R6 restart events
    do_reset(); step(20); cswitch_done = 1; wait_pulse(200, 1, lat, wk);
    check("R6 clock switch restart", lat, 33);
    do_reset(); step(20); pwrsave = 1; wait_pulse(200, 1, lat, wk);
    check("R6 power-save restart", lat, 33);
    do_reset(); step(20); clr = 1; wait_pulse(200, 1, lat, wk);
    check("R6 clear restart", lat, 33);
    do_reset(); step(20); sleep = 1; step(5); sleep = 0; wait_pulse(200, 1, lat, wk);
    check("R6 sleep exit restart", lat, 33);

    // R7 window mode, period 32, threshold 24
    win_dis = 0;
    do_reset(); step(10); clr = 1; wait_pulse(5, 1, lat, wk);
    check("R7 early clear request", lat, 1);
    check("R7 early clear is reset", wk, 0);
    wait_pulse(100, 1, lat, wk);
    check("R7 restart after early clear", lat, 32);
    do_reset(); step(23); clr = 1; wait_pulse(5, 1, lat, wk);
    check("R7 clear at 23 early", lat, 1);
    do_reset(); step(24); clr = 1; wait_pulse(100, 1, lat, wk);
    check("R7 clear at 24 accepted", lat, 33);

    // R10 disabled: clear ignored, no timeout
    hw_en = 0;
    do_reset(); clr = 1; wait_pulse(100, 1, lat, wk);
    check("R10 disabled clear and count", lat, -1);
    win_dis = 1;

    // R4 software enable
    swen_we = 1; swen_d = 1; wait_pulse(100, 1, lat, wk);
    check("R4 software enable runs", lat, 33);
    swen_we = 1; swen_d = 0; wait_pulse(100, 1, lat, wk);
    check("R4 software disable stops", lat, -1);

    // R5 reset clears software enable
    swen_we = 1; swen_d = 1; step(1);
    do_reset(); wait_pulse(100, 1, lat, wk);
    check("R5 reset clears soft enable", lat, -1);
    hw_en = 1;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule